// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block is the processor-side sequencer for an external bus on which address and data share one set of lines. An internal requester hands it one operation at a time: a single-word read, a single-word write, or a four-word burst read for a cache-line refill. The block drives the address with a latch strobe and marks the direction with read or write strobes. For reads it turns the shared lines around before enabling memory drivers. It finishes on the memory's acknowledge, on read-clock-enable strobes, or on a bus error, and hands read data or an error indication back to the requester as a one-cycle response.

The block also marks writes that fall in the same memory page as the write just before them, so a page-mode memory can retire them quickly. The same output pin carries the burst indication during refill reads. When an external master asks for the bus while nothing is in flight, the block turns off all its bus drivers and raises a grant until the request is removed. Pad cells are not part of the block: output-enable signals stand in for tri-state control.

Top module: `mbus_master`

## Requirements
- R1: Every transaction begins with exactly one cycle in which `ale` is 1, `ad_oe` is 1 and `ad_out` carries the word address (zero-extended) of the transaction.
- R2: `bus_rd` is 1 from the address cycle to the end of a read, and `bus_wr` is 1 from the address cycle to the end of a write. The two are never 1 together and both are 0 while idle.
- R3: `data_en` is 1 only in the data phase of a read, when `ad_oe` is 0. It is 0 in the address cycle, throughout writes, and while idle.
- R4: A burst read (`req_kind` = 2) drives `burst_near` = 1 through the whole read, and its address has the low log2(WORDS) bits forced to zero. Single reads (`req_kind` = 0) leave `burst_near` at 0.
- R5: A write (`req_kind` = 1) drives `burst_near` = 1 during its address and data cycles only when the previous accepted transaction was also a write and both addresses have the same page number, taken as the address bits above log2(PAGE_WORDS). Reset, any read and any grant period clear this tracking.
- R6: A write holds its data on `ad_out` until `ack` is sampled at 1. The cycle after that, `rsp_valid` is 1 for one cycle with `rsp_err` = 0.
- R7: In a read data phase each cycle with `rdcen` = 1 stores `ad_in` into the next buffer slot, starting at slot 0 and counting up. Slot i appears on `rsp_rdata[i*DW +: DW]`. A read ends once `ack` has been seen and 1 word (single) or WORDS words (burst) are stored. `rsp_valid` pulses the cycle after that.
- R8: `berr` sampled at 1 in a data phase ends the transaction, and `rsp_valid` pulses the next cycle. `rsp_err` is 1 for a read and 0 for a write.
- R9: If `busreq` is 1 while idle, the next cycle `busgnt` is 1 and `ad_oe` and `ctl_oe` are 0. This holds until the cycle after `busreq` is sampled at 0. `busreq` takes priority over a pending request in the same cycle.
- R10: `req_ready` is 0 while granted or busy. A request held during a grant is accepted only after the grant ends, and `ale` is never 1 in the cycle after `busgnt` is 1.
- R11: After reset the block is idle: `req_ready` = 1, `ctl_oe` = 1, and all of `ale`, `bus_rd`, `bus_wr`, `data_en`, `burst_near`, `ad_oe`, `busgnt`, `rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Requester has an operation pending (held until accepted) |
| req_kind | input | 2 | 0 single read, 1 write, 2 burst read |
| req_addr | input | AW | Word address of the operation |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Operation accepted at this edge when req_valid is 1 |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Read ended by bus error |
| rsp_rdata | output | WORDS*DW | Read buffer, slot 0 in the low bits |
| ad_out | output | DW | Value driven on the shared address/data lines |
| ad_oe | output | 1 | Drive enable for the shared lines |
| ad_in | input | DW | Value present on the shared lines |
| ctl_oe | output | 1 | Drive enable for the control strobes |
| ale | output | 1 | Address latch strobe |
| bus_rd | output | 1 | Read transaction in progress |
| bus_wr | output | 1 | Write transaction in progress |
| data_en | output | 1 | Memory may drive the shared lines |
| burst_near | output | 1 | Burst request on reads, same-page write on writes |
| ack | input | 1 | Memory acknowledge |
| rdcen | input | 1 | Read word valid on the shared lines |
| berr | input | 1 | Bus error |
| busreq | input | 1 | External master requests the bus |
| busgnt | output | 1 | Bus released to the external master |

## Verification
The bench builds the block with 16-bit lines, a 12-bit word address, four-word bursts and a 16-word page. The small page puts page crossings and same-page writes at short addresses, so the write-near indication can be driven on, off, and reset by a read or a grant within a few transactions. The narrow buffer lets the whole four-word burst result be compared as one 64-bit value, with gaps between read strobes and an acknowledge that arrives late.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_RDATA,
        ST_WDATA,
        ST_GRANT
    } bus_st_e;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_BURST = 2'd2
    } op_e;

endpackage

// File: rtl/mbus_near_track.sv
module mbus_near_track #(
    parameter int AW         = 30,
    parameter int PAGE_WORDS = 512
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_start,
    input  logic          rd_start,
    input  logic          clear,
    input  logic [AW-1:0] addr,
    output logic          near_o
);
    localparam int PW  = $clog2(PAGE_WORDS);
    localparam int PGW = AW - PW;

    typedef struct packed {
        logic           valid;
        logic [PGW-1:0] page;
    } trk_t;

    trk_t q, d;

    always_comb begin
        d = q;
        if (clear || rd_start) begin
            d.valid = 1'b0;
        end else if (wr_start) begin
            d.valid = 1'b1;
            d.page  = addr[AW-1:PW];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign near_o = q.valid && (addr[AW-1:PW] == q.page);

    AST_NEAR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (clear || rd_start) |=> !near_o); // R5

endmodule

// File: rtl/mbus_rdbuf.sv
module mbus_rdbuf #(
    parameter int DW    = 32,
    parameter int WORDS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  cap,
    input  logic [DW-1:0]         word_in,
    output logic [$clog2(WORDS+1)-1:0] count,
    output logic [WORDS*DW-1:0]   data
);
    localparam int CW = $clog2(WORDS + 1);

    typedef struct packed {
        logic [CW-1:0]             cnt;
        logic [WORDS-1:0][DW-1:0]  slot;
    } buf_t;

    buf_t q, d;

    always_comb begin
        d = q;
        if (clear) begin
            d.cnt = '0;
        end else if (cap && (q.cnt < CW'(WORDS))) begin
            for (int i = 0; i < WORDS; i++) begin
                if (q.cnt == CW'(i)) d.slot[i] = word_in;
            end
            d.cnt = q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign count = q.cnt;
    assign data  = q.slot;

    AST_BUF_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && cap && (count < CW'(WORDS))) |=> (count == $past(count) + CW'(1))); // R7

endmodule

// File: rtl/mbus_master.sv
module mbus_master
    import mbus_pkg::*;
#(
    parameter int DW         = 32,
    parameter int AW         = 30,
    parameter int WORDS      = 4,
    parameter int PAGE_WORDS = 512
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [1:0]          req_kind,
    input  logic [AW-1:0]       req_addr,
    input  logic [DW-1:0]       req_wdata,
    output logic                req_ready,
    output logic                rsp_valid,
    output logic                rsp_err,
    output logic [WORDS*DW-1:0] rsp_rdata,
    output logic [DW-1:0]       ad_out,
    output logic                ad_oe,
    input  logic [DW-1:0]       ad_in,
    output logic                ctl_oe,
    output logic                ale,
    output logic                bus_rd,
    output logic                bus_wr,
    output logic                data_en,
    output logic                burst_near,
    input  logic                ack,
    input  logic                rdcen,
    input  logic                berr,
    input  logic                busreq,
    output logic                busgnt
);
    localparam int CW    = $clog2(WORDS + 1);
    localparam int ALIGN = $clog2(WORDS);

    typedef struct packed {
        bus_st_e       st;
        op_e           op;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          near;
        logic          ack_seen;
        logic          rsp_valid;
        logic          rsp_err;
    } ctl_t;

    ctl_t q, d;

    logic          accept, req_is_wr, req_is_burst;
    logic          near_hit;
    logic          cap;
    logic [CW-1:0] got_cnt;
    logic [CW:0]   words_now;
    logic [CW:0]   words_need;
    logic [AW-1:0] aligned_addr;

    assign req_ready    = (q.st == ST_IDLE) && !busreq;
    assign accept       = req_ready && req_valid;
    assign req_is_wr    = (req_kind == OP_WRITE);
    assign req_is_burst = (req_kind == OP_BURST);
    assign aligned_addr = {req_addr[AW-1:ALIGN], {ALIGN{1'b0}}};
    assign cap          = (q.st == ST_RDATA) && rdcen && !berr;
    assign words_now    = {1'b0, got_cnt} + {{CW{1'b0}}, rdcen};
    assign words_need   = (q.op == OP_BURST) ? (CW+1)'(WORDS) : (CW+1)'(1);

    mbus_near_track #(.AW(AW), .PAGE_WORDS(PAGE_WORDS)) u_near (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_start (accept && req_is_wr),
        .rd_start (accept && !req_is_wr),
        .clear    (q.st == ST_GRANT),
        .addr     (req_addr),
        .near_o   (near_hit)
    );

    mbus_rdbuf #(.DW(DW), .WORDS(WORDS)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .cap     (cap),
        .word_in (ad_in),
        .count   (got_cnt),
        .data    (rsp_rdata)
    );

    always_comb begin
        d           = q;
        d.rsp_valid = 1'b0;
        d.rsp_err   = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (busreq) begin
                    d.st = ST_GRANT;
                end else if (req_valid) begin
                    d.st       = ST_ADDR;
                    d.op       = req_is_wr ? OP_WRITE : (req_is_burst ? OP_BURST : OP_READ);
                    d.addr     = req_is_burst ? aligned_addr : req_addr;
                    d.wdata    = req_wdata;
                    d.near     = req_is_wr && near_hit;
                    d.ack_seen = 1'b0;
                end
            end
            ST_ADDR: begin
                d.st = (q.op == OP_WRITE) ? ST_WDATA : ST_RDATA;
            end
            ST_RDATA: begin
                if (berr) begin
                    d.st        = ST_IDLE;
                    d.rsp_valid = 1'b1;
                    d.rsp_err   = 1'b1;
                end else begin
                    if (ack) d.ack_seen = 1'b1;
                    if ((q.ack_seen || ack) && (words_now >= words_need)) begin
                        d.st        = ST_IDLE;
                        d.rsp_valid = 1'b1;
                    end
                end
            end
            ST_WDATA: begin
                if (berr || ack) begin
                    d.st        = ST_IDLE;
                    d.rsp_valid = 1'b1;
                end
            end
            ST_GRANT: begin
                if (!busreq) d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.op   <= OP_READ;
        end else begin
            q <= d;
        end
    end

    // Bus-side outputs decoded from the registered state
    logic in_addr, in_rd, in_wd;
    assign in_addr    = (q.st == ST_ADDR);
    assign in_rd      = (q.st == ST_RDATA);
    assign in_wd      = (q.st == ST_WDATA);

    assign ale        = in_addr;
    assign ad_oe      = in_addr || in_wd;
    assign ad_out     = in_addr ? DW'(q.addr) : (in_wd ? q.wdata : '0);
    assign bus_rd     = (in_addr || in_rd) && (q.op != OP_WRITE);
    assign bus_wr     = (in_addr || in_wd) && (q.op == OP_WRITE);
    assign data_en    = in_rd;
    assign burst_near = ((in_addr || in_rd) && (q.op == OP_BURST)) ||
                        ((in_addr || in_wd) && (q.op == OP_WRITE) && q.near);
    assign ctl_oe     = (q.st != ST_GRANT);
    assign busgnt     = (q.st == ST_GRANT);
    assign rsp_valid  = q.rsp_valid;
    assign rsp_err    = q.rsp_err;

    AST_ALE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (ad_oe && $past(req_ready))); // R1
    AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale); // R1
    AST_ONE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr)); // R2
    AST_DEN_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
        data_en |-> (bus_rd && !ad_oe && !ale)); // R3
    AST_BURST_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (ale && bus_rd && burst_near) |-> (ad_out[ALIGN-1:0] == '0)); // R4
    AST_BERR_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (berr && (data_en || (bus_wr && !ale))) |=> rsp_valid); // R8
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R6
    AST_GNT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        busgnt |-> (!ad_oe && !ctl_oe && !req_ready)); // R9
    AST_GNT_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        busgnt |=> !ale); // R10

endmodule

// File: tb/sim_mbus_master.sv
module sim_mbus_master;
    localparam int DW = 16, AW = 12, WORDS = 4, PAGE_WORDS = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_kind = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_valid, rsp_err;
    logic [WORDS*DW-1:0] rsp_rdata;
    logic [DW-1:0] ad_out, ad_in = '0;
    logic ad_oe, ctl_oe, ale, bus_rd, bus_wr, data_en, burst_near, busgnt;
    logic ack = 1'b0, rdcen = 1'b0, berr = 1'b0, busreq = 1'b0;

    int checks = 0, fails = 0;

    always #10 clk = ~clk;

    mbus_master #(.DW(DW), .AW(AW), .WORDS(WORDS), .PAGE_WORDS(PAGE_WORDS)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .ctl_oe(ctl_oe), .ale(ale),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .data_en(data_en), .burst_near(burst_near),
        .ack(ack), .rdcen(rdcen), .berr(berr), .busreq(busreq), .busgnt(busgnt)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Present a request and return at the negedge after the accepting edge
    task automatic issue(input logic [1:0] kind, input logic [AW-1:0] addr, input logic [DW-1:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_kind = kind; req_addr = addr; req_wdata = wd;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 req_ready", req_ready, 1);
        chk("R11 ctl_oe", ctl_oe, 1);
        chk("R11 idle strobes", {ale, bus_rd, bus_wr, data_en, burst_near, ad_oe, busgnt, rsp_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 idle after release", {ale, bus_rd, bus_wr, data_en, ad_oe}, 0);
    endtask

    task automatic t_write(input logic [AW-1:0] a, input logic [DW-1:0] w, input logic exp_near);
        issue(2'd1, a, w);
        chk("R1 ale write", {ale, ad_oe}, 2'b11);
        chk("R1 address", ad_out, 64'(a));
        chk("R2 write dir", {bus_wr, bus_rd}, 2'b10);
        chk("R5 near addr cycle", burst_near, exp_near);
        chk("R3 no data_en addr", data_en, 0);
        @(negedge clk);
        chk("R6 data driven", ad_out, 64'(w));
        chk("R3 no data_en write", data_en, 0);
        chk("R5 near data cycle", burst_near, exp_near);
        chk("R1 ale single", ale, 0);
        @(negedge clk);
        chk("R6 held without ack", {bus_wr, ad_oe, rsp_valid}, 3'b110);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        chk("R6 rsp after ack", {rsp_valid, rsp_err}, 2'b10);
        chk("R2 write ended", {bus_wr, bus_rd}, 0);
    endtask

    task automatic t_read(input logic [AW-1:0] a, input logic [DW-1:0] w);
        issue(2'd0, a, '0);
        chk("R2 read dir", {bus_rd, bus_wr}, 2'b10);
        chk("R1 read address", ad_out, 64'(a));
        chk("R4 single no burst", burst_near, 0);
        chk("R3 no data_en addr", data_en, 0);
        @(negedge clk);
        chk("R3 turnaround", {data_en, ad_oe}, 2'b10);
        ad_in = w; rdcen = 1'b1; ack = 1'b1;
        @(negedge clk);
        rdcen = 1'b0; ack = 1'b0;
        chk("R7 single done", {rsp_valid, rsp_err}, 2'b10);
        chk("R7 single word", rsp_rdata[DW-1:0], 64'(w));
        chk("R3 idle no data_en", data_en, 0);
    endtask

    task automatic t_read_late_ack();
        issue(2'd0, 12'h040, '0);
        @(negedge clk);
        ad_in = 16'h5A5A; rdcen = 1'b1;
        @(negedge clk);
        rdcen = 1'b0; ad_in = 16'hFFFF;
        chk("R7 waits for ack", {rsp_valid, bus_rd}, 2'b01);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        chk("R7 late ack done", rsp_valid, 1);
        chk("R7 late ack word", rsp_rdata[DW-1:0], 64'h5A5A);
    endtask

    task automatic t_burst();
        issue(2'd2, 12'h0B6, '0);
        chk("R4 aligned", ad_out, 64'h0B4);
        chk("R4 burst flag addr", burst_near, 1);
        @(negedge clk);
        for (int i = 0; i < WORDS; i++) begin
            ad_in = 16'hA000 + 16'(i); rdcen = 1'b1; ack = (i == 0);
            @(negedge clk);
            rdcen = 1'b0; ack = 1'b0;
            if (i < WORDS - 1) begin
                chk("R4 burst flag data", burst_near, 1);
                chk("R7 burst not done", rsp_valid, 0);
            end
            if (i == 1) begin
                @(negedge clk);
                chk("R7 gap no done", rsp_valid, 0);
            end
        end
        chk("R7 burst done", {rsp_valid, rsp_err}, 2'b10);
        chk("R7 ascending order", rsp_rdata, 64'hA003_A002_A001_A000);
    endtask

    task automatic t_berr_read();
        issue(2'd0, 12'h100, '0);
        @(negedge clk);
        berr = 1'b1;
        @(negedge clk);
        berr = 1'b0;
        chk("R8 read error", {rsp_valid, rsp_err}, 2'b11);
        chk("R8 read ended", bus_rd, 0);
    endtask

    task automatic t_berr_write();
        issue(2'd1, 12'h104, 16'h1234);
        @(negedge clk);
        berr = 1'b1;
        @(negedge clk);
        berr = 1'b0;
        chk("R8 write error no flag", {rsp_valid, rsp_err}, 2'b10);
        chk("R8 write ended", bus_wr, 0);
    endtask

    task automatic t_grant();
        @(negedge clk);
        busreq = 1'b1;
        req_valid = 1'b1; req_kind = 2'd1; req_addr = 12'h019; req_wdata = 16'hBEEF;
        @(negedge clk);
        chk("R9 grant", busgnt, 1);
        chk("R9 released", {ad_oe, ctl_oe}, 0);
        chk("R10 not ready", req_ready, 0);
        repeat (3) begin
            @(negedge clk);
            chk("R9 grant held", {busgnt, ale}, 2'b10);
        end
        busreq = 1'b0;
        @(negedge clk);
        chk("R9 grant dropped", {busgnt, ctl_oe, ale}, 3'b010);
        chk("R10 ready again", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 held request starts", {ale, bus_wr}, 2'b11);
        chk("R10 held address", ad_out, 64'h019);
        chk("R5 grant clears near", burst_near, 0);
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        chk("R6 write after grant", rsp_valid, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_write(12'h003, 16'h1111, 1'b0);   // R5 first write after reset
        t_write(12'h005, 16'h2222, 1'b1);   // R5 same page
        t_write(12'h014, 16'h3333, 1'b0);   // R5 page crossing
        t_write(12'h015, 16'h4444, 1'b1);
        t_read(12'h016, 16'hC0DE);
        t_write(12'h017, 16'h5555, 1'b0);   // R5 read cleared tracking
        t_write(12'h018, 16'h6666, 1'b1);
        t_grant();
        t_burst();
        t_read_late_ack();
        t_berr_read();
        t_berr_write();
        t_write(12'h105, 16'h7777, 1'b1);   // R5 errored write still tracked
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule